// File: doc/BRIEF.md
# Multi-Channel All-Feed Watchdog

This block is a hardware watchdog that several independent software agents must keep alive together. A 32-bit down-counter is clocked by a slow tick enable, nominally 32768 ticks per second. If the counter reaches its end, the block raises a reset request. Up to eight feed channels exist, and a programmable mask chooses which of them take part. Each channel is fed by writing a fixed key word to it. The counter is reloaded only when every enabled channel has been fed since the last reload, so a single stalled task is enough to bring on a reset, even while the other tasks keep feeding.

Software first writes the channel mask and the reload value through a simple register-write port, then issues a start command. From that point on, the mask and the reload value are frozen until system reset. A pause pin holds the counter still, for example while a debugger has the processors halted. A status vector shows which channels have been fed in the current period.

Top module: `wdg_allfeed`

## Requirements
- R1: After reset, resetReq is 0 and fedFlags is 0, and no reset request is made before a start command however many ticks arrive.
- R2: Before start, a write to address 1 loads the channel mask from wrData[7:0], and a write to address 2 loads the 32-bit reload value. A write of any data to address 0 starts the watchdog and loads the counter with the reload value.
- R3: While running and not paused, each cycle with tickEn high counts one tick. Reload value R gives a timeout of R+1 ticks. On the expiring tick's clock edge, resetReq rises for exactly one cycle, the counter reloads, counting goes on, and all fed flags clear.
- R4: While running, writing 0x6E524635 to address 8+c sets fedFlags[c] when mask bit c is set. Feed writes made before start change nothing.
- R5: A write to a channel address with any value other than 0x6E524635 leaves fedFlags unchanged.
- R6: A write to a channel whose mask bit is clear is ignored, even when it carries the key word.
- R7: When a feed makes every enabled channel fed, the counter reloads and all fed flags clear on that same clock edge. The counter is never reloaded while some enabled channel is still unfed, and a zero mask never reloads it.
- R8: After start, writes to addresses 0, 1 and 2 are ignored until system reset.
- R9: While pause is high, ticks are ignored and the counter holds its value.
- R10: If the completing feed falls on the same cycle as an expiring tick, the reload wins and no reset request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous system reset |
| tickEn | input | 1 | One-cycle tick enable from the slow timebase |
| pause | input | 1 | Freezes the counter while high |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Write address: 0 start, 1 mask, 2 reload, 8..15 feed channels 0..7 |
| wrData | input | 32 | Write data |
| resetReq | output | 1 | One-cycle reset request on expiry |
| fedFlags | output | 8 | Channels fed since the last reload |

## Verification
The bench drives the last feed of a period on the very tick that would expire the counter. A design that lets expiry win there fires a reset that should not happen, and the scoreboard flags it as an unexpected pulse. It feeds disabled channels, sends near-miss key words and rewrites the mask, reload value and start after the lock. A design that accepts any of these shows the wrong fedFlags, or its next reset request arrives at the wrong cycle. Pause windows and expiries with flags partly set are also covered, so a counter that drifts while paused, or flags that survive an expiry, put the pulse at the wrong cycle or leave the status wrong.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;
  // Strobes sent from the control module to the counter datapath
  typedef struct packed {
    logic start;       // begin counting, load counter from reload register
    logic loadReload;  // capture write data into reload register
    logic refresh;     // all enabled channels fed: reload counter
    logic countEn;     // a tick that counts this cycle
  } wdgStrobe_t;
endpackage

// File: rtl/wdg_ctrl.sv
`timescale 1ns/1ps
module wdg_ctrl
  import wdg_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter logic [DATA_W-1:0] FEED_KEY = 32'h6E524635
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              tickEn,
  input  logic              pause,
  input  logic              expireNow,
  output wdgStrobe_t        strobe,
  output logic              running,
  output logic [NUM_CH-1:0] enMask,
  output logic [NUM_CH-1:0] fedFlags
);
  localparam int CH_IDX_W = $clog2(NUM_CH);
  localparam int REG_W    = ADDR_W - 1;
  localparam logic [REG_W-1:0] REG_START  = REG_W'(0);
  localparam logic [REG_W-1:0] REG_MASK   = REG_W'(1);
  localparam logic [REG_W-1:0] REG_RELOAD = REG_W'(2);

  logic              runningQ;
  logic [NUM_CH-1:0] enMaskQ;
  logic [NUM_CH-1:0] fedQ;
  logic [NUM_CH-1:0] feedHit;
  logic [NUM_CH-1:0] nextFed;
  logic              regWr, chWr, keyMatch, allFed;
  logic [REG_W-1:0]  regSel;
  logic [CH_IDX_W-1:0] chSel;

  assign regSel   = wrAddr[REG_W-1:0];
  assign chSel    = wrAddr[CH_IDX_W-1:0];
  assign regWr    = wrEn && !wrAddr[ADDR_W-1] && !runningQ;
  assign chWr     = wrEn && wrAddr[ADDR_W-1] && runningQ;
  assign keyMatch = (wrData == FEED_KEY);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_feed
    assign feedHit[i] = chWr && keyMatch && enMaskQ[i] && (chSel == CH_IDX_W'(i));
  end

  assign nextFed = fedQ | feedHit;
  assign allFed  = runningQ && (|enMaskQ) && ((nextFed & enMaskQ) == enMaskQ);

  always_comb begin
    strobe.start      = regWr && (regSel == REG_START);
    strobe.loadReload = regWr && (regSel == REG_RELOAD);
    strobe.refresh    = allFed;
    strobe.countEn    = runningQ && tickEn && !pause;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runningQ <= 1'b0;
      enMaskQ  <= '0;
      fedQ     <= '0;
    end else begin
      if (strobe.start) runningQ <= 1'b1;
      if (regWr && (regSel == REG_MASK)) enMaskQ <= wrData[NUM_CH-1:0];
      if (allFed || expireNow) fedQ <= '0;
      else                     fedQ <= nextFed;
    end
  end

  assign running  = runningQ;
  assign enMask   = enMaskQ;
  assign fedFlags = fedQ;
endmodule

// File: rtl/wdg_datapath.sv
`timescale 1ns/1ps
module wdg_datapath
  import wdg_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] RESET_RELOAD = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdgStrobe_t       strobe,
  input  logic [CNT_W-1:0] wrData,
  output logic             expireNow,
  output logic             resetReq,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] reloadQ;
  logic             resetReqQ;
  logic             atZero;

  assign atZero    = (cntQ == '0);
  assign expireNow = strobe.countEn && atZero && !strobe.refresh && !strobe.start;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ      <= '0;
      reloadQ   <= RESET_RELOAD;
      resetReqQ <= 1'b0;
    end else begin
      resetReqQ <= expireNow;
      if (strobe.loadReload) reloadQ <= wrData;
      if (strobe.start || strobe.refresh) cntQ <= reloadQ;
      else if (strobe.countEn)            cntQ <= atZero ? reloadQ : cntQ - 1'b1;
    end
  end

  assign resetReq = resetReqQ;
  assign cnt      = cntQ;
endmodule

// File: rtl/wdg_allfeed.sv
`timescale 1ns/1ps
module wdg_allfeed
  import wdg_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4,
  parameter logic [CNT_W-1:0] FEED_KEY     = 32'h6E524635,
  parameter logic [CNT_W-1:0] RESET_RELOAD = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              pause,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  output logic              resetReq,
  output logic [NUM_CH-1:0] fedFlags
);
  wdgStrobe_t        strobeW;
  logic              expireW;
  logic              runningW;
  logic [NUM_CH-1:0] enMaskW;
  logic [CNT_W-1:0]  cntW;

  wdg_ctrl #(
    .NUM_CH(NUM_CH), .DATA_W(CNT_W), .ADDR_W(ADDR_W), .FEED_KEY(FEED_KEY)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .tickEn(tickEn), .pause(pause), .expireNow(expireW), .strobe(strobeW),
    .running(runningW), .enMask(enMaskW), .fedFlags(fedFlags)
  );

  wdg_datapath #(
    .CNT_W(CNT_W), .RESET_RELOAD(RESET_RELOAD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobeW), .wrData(wrData),
    .expireNow(expireW), .resetReq(resetReq), .cnt(cntW)
  );
endmodule

// File: rtl/wdg_allfeed_chk.sv
`timescale 1ns/1ps
module wdg_allfeed_chk #(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              pause,
  input logic              wrEn,
  input logic              running,
  input logic              resetReq,
  input logic [NUM_CH-1:0] fedFlags,
  input logic [NUM_CH-1:0] enMask,
  input logic [CNT_W-1:0]  cnt
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (!resetReq && fedFlags == '0));

  assert_count_down_R3: assert property (@(posedge clk) disable iff (!rstN)
    (running && tickEn && !pause && !wrEn && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  assert_expiry_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> (fedFlags == '0));

  assert_only_enabled_R6: assert property (@(posedge clk) disable iff (!rstN)
    (fedFlags & ~enMask) == '0);

  assert_never_all_fed_R7: assert property (@(posedge clk) disable iff (!rstN)
    (running && |enMask) |-> ((fedFlags & enMask) != enMask));

  assert_mask_locked_R8: assert property (@(posedge clk) disable iff (!rstN)
    running |=> $stable(enMask));

  assert_pause_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (running && pause && !wrEn) |=> $stable(cnt));
endmodule

bind wdg_allfeed wdg_allfeed_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .pause(pause), .wrEn(wrEn),
  .running(runningW), .resetReq(resetReq), .fedFlags(fedFlags),
  .enMask(enMaskW), .cnt(cntW)
);

// File: tb/wdg_allfeed_tb.sv
`timescale 1ns/1ps
module wdg_allfeed_tb;
  localparam logic [31:0] KEY = 32'h6E524635;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0, pause = 1'b0, wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        resetReq;
  logic [7:0]  fedFlags;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  string phaseTag = "R1";
  int    expCyc[$];
  string expTag[$];

  // reference state, built from the requirements
  bit          mRunning = 0;
  logic [7:0]  mMask = '0, mFed = '0;
  logic [31:0] mReload = 32'hFFFF_FFFF, mCnt = '0;

  wdg_allfeed u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .pause(pause), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .resetReq(resetReq), .fedFlags(fedFlags)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic checkFed(string tag, logic [7:0] exp);
    checks++;
    if (fedFlags !== exp) begin
      fails++;
      $display("FAIL %s: fedFlags actual %h expected %h", tag, fedFlags, exp);
    end
  endtask

  // one operation: drive for one cycle, update the reference, then release
  task automatic step(bit we, logic [3:0] addr, logic [31:0] data, bit tk);
    logic [7:0] nf;
    bit hitAll, cEn;
    int ch;
    @(negedge clk);
    wrEn = we; wrAddr = addr; wrData = data; tickEn = tk;
    nf = mFed;
    ch = int'(addr) - 8;
    if (we && addr[3] && mRunning && data == KEY && mMask[ch]) nf[ch] = 1'b1;
    hitAll = mRunning && (mMask != 0) && ((nf & mMask) == mMask);
    cEn = mRunning && tk && !pause;
    if (we && addr == 4'd0 && !mRunning) begin
      mRunning = 1; mCnt = mReload;
    end else if (hitAll) begin
      mCnt = mReload; nf = '0;
    end else if (cEn) begin
      if (mCnt == 0) begin
        expCyc.push_back(cyc + 1); expTag.push_back(phaseTag);
        mCnt = mReload; nf = '0;
      end else mCnt = mCnt - 1;
    end
    mFed = nf;
    if (we && addr == 4'd1 && !mRunning) mMask = data[7:0];
    if (we && addr == 4'd2 && !mRunning) mReload = data;
    @(negedge clk);
    wrEn = 0; tickEn = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(0, 4'd0, 32'd0, 1);
  endtask

  task automatic feed(int ch, logic [31:0] data);
    step(1, 4'(8 + ch), data, 0);
  endtask

  // monitor: every reset request must match the next expected item
  initial begin : monitor
    int e;
    string t;
    forever begin
      @(posedge clk); #5;
      if (rstN && resetReq) begin
        checks++;
        if (expCyc.size() == 0) begin
          fails++;
          $display("FAIL R3: unexpected reset request at cycle %0d, actual 1 expected 0", cyc);
        end else begin
          e = expCyc.pop_front(); t = expTag.pop_front();
          if (e != cyc) begin
            fails++;
            $display("FAIL %s: reset request cycle actual %0d expected %0d", t, cyc, e);
          end
        end
      end
    end
  end

  initial begin : watchdog
    #(20 * 100000);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checks++;
    if (resetReq !== 1'b0) begin fails++; $display("FAIL R1: resetReq actual %b expected 0", resetReq); end
    checkFed("R1", 8'h00);

    phaseTag = "R1";
    ticks(6);                           // no start yet: no request
    feed(0, KEY);
    checkFed("R4 feed before start", 8'h00);

    step(1, 4'd1, 32'h0000_0005, 0);    // R2 mask: channels 0 and 2
    step(1, 4'd2, 32'd3, 0);            // R2 reload 3 -> 4 ticks
    phaseTag = "R2";
    step(1, 4'd0, 32'd0, 0);            // start
    ticks(4);

    phaseTag = "R3";
    feed(0, KEY);
    checkFed("R4", 8'h01);
    ticks(4);
    checkFed("R3 expiry clears flags", 8'h00);

    feed(0, KEY);
    checkFed("R4", 8'h01);
    feed(1, KEY);
    checkFed("R6 disabled channel", 8'h01);
    feed(2, 32'h1234_5678);
    checkFed("R5 wrong value", 8'h01);
    feed(2, KEY ^ 32'h1);
    checkFed("R5 near-miss key", 8'h01);
    ticks(2);
    feed(2, KEY);
    checkFed("R7 all fed clears", 8'h00);
    phaseTag = "R7";
    ticks(4);

    step(1, 4'd2, 32'd10, 0);           // locked
    step(1, 4'd1, 32'h0000_00FF, 0);    // locked
    step(1, 4'd0, 32'd0, 0);            // second start ignored
    feed(1, KEY);
    checkFed("R8 mask locked", 8'h00);
    phaseTag = "R8";
    ticks(4);

    phaseTag = "R9";
    ticks(2);
    pause = 1;
    ticks(8);
    pause = 0;
    ticks(2);

    phaseTag = "R10";
    ticks(3);                           // counter now at zero
    feed(0, KEY);
    checkFed("R10", 8'h01);
    step(1, 4'd10, KEY, 1);             // final feed on the expiring tick
    checkFed("R10 refresh wins", 8'h00);
    ticks(4);

    repeat (4) @(negedge clk);
    checks++;
    if (expCyc.size() != 0) begin
      fails++;
      $display("FAIL R3: missing reset requests actual %0d pending expected 0", expCyc.size());
    end
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule